// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It fetches a word from a small internal instruction store and decodes it. It reads two operands from a 32-entry register file, computes a result in the ALU and, in the same cycle, writes a register, writes a data word or redirects the program counter. The instruction set is small: register-register add, subtract, AND, OR and signed set-less-than, plus word load, word store and branch-if-equal.

Decoding takes two stages. A main decoder turns the 6-bit opcode into nine control lines, two of which form an ALU operation class. A second, smaller decoder combines that class with the 6-bit function field to pick the ALU operation. A branch is taken when the branch line and the ALU zero flag are both true.

Both memories live inside the core. While reset is held, a test environment writes program and data words through a load port. It reads data words back through a peek port at any time. Releasing reset starts execution at address 0.

Top module: `sc_core`

## Requirements
- R1: Synchronous reset holds the program counter at 0, and execution starts from address 0 on the first edge after reset is released.
- R2: Outside a taken branch, the program counter moves forward by 4 on every clock edge.
- R3: The register file holds 32 registers of 32 bits, read combinationally through two ports. A value written by one instruction is visible to the next instruction.
- R4: Register 0 always reads as zero, and writes to it are discarded.
- R5: Opcode 0x00 selects a register-register operation that writes the rd field (instr[15:11]). The function field instr[5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A set-less-than. The sources are rs (instr[25:21]) and rt (instr[20:16]).
- R6: Set-less-than writes 1 when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R7: Opcode 0x23 (load) writes rt with the data word at rs plus instr[15:0] sign-extended. Data words are indexed by address bits [N+1:2], where N is log2 of the data word count, so the index wraps modulo the memory size.
- R8: Opcode 0x2B (store) writes the value of rt to the data word at rs plus the sign-extended offset, and changes no register.
- R9: Opcode 0x04 with rs equal to rt loads the program counter with PC+4 plus the sign-extended offset shifted left by two. An offset of -1 holds the core on the same instruction.
- R10: Opcode 0x04 with rs different from rt has no effect except advancing the program counter by 4.
- R11: Any other opcode writes neither a register nor data memory.
- R12: While reset is high, the load port writes a word into the instruction memory (select 0) or the data memory (select 1) at a word index. The peek port returns the data word at a word index combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| ld_we | input | 1 | Load-port write strobe (honoured only during reset) |
| ld_sel_dmem | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | XLEN | Load-port word index |
| ld_data | input | XLEN | Load-port write data |
| peek_addr | input | XLEN | Data-memory word index for read-back |
| peek_data | output | XLEN | Data word at peek_addr |
| pc_o | output | XLEN | Current program counter |

## Verification
The bench keeps the default instruction store of 64 words, which holds both a random program of about thirty-five instructions and a directed one. It shrinks the data memory to 32 words. Stores placed beyond the top of that smaller array therefore reach the wrap-around of the word index, and this checks that only address bits [6:2] select a word. The random program's results are compared with a register model kept in the bench. The directed program covers signed compares, writes to register 0, branches taken and not taken, negative offsets and an unknown opcode whose fields look like a load.

// File: rtl/risc_pkg.sv
package risc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // operation class handed from the main decoder to the ALU decoder
    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } op_class_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_fn_e;

    typedef struct packed {
        logic      dst_rd;   // destination from rd field, else rt
        logic      src_imm;  // second operand is the extended immediate
        logic      wb_mem;   // write-back from data memory, else ALU
        logic      reg_we;
        logic      mem_rd;
        logic      mem_we;
        logic      branch;
        op_class_e cls;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import risc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0, reg_we: 1'b0,
                 mem_rd: 1'b0, mem_we: 1'b0, branch: 1'b0, cls: CLS_ADD};
        case (opcode)
            OP_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.cls    = CLS_FUNCT;
            end
            OP_LOAD: begin
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OP_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.cls    = CLS_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu_ctl.sv
module sc_alu_ctl
    import risc_pkg::*;
(
    input  op_class_e  cls,
    input  logic [5:0] funct,
    output alu_fn_e    fn
);

    always_comb begin
        case (cls)
            CLS_SUB:   fn = ALU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn = ALU_ADD;
                endcase
            end
            default:   fn = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import risc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    logic lt_signed;

    always_comb begin
        lt_signed = $signed(a) < $signed(b);
        case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, lt_signed};
            default: y = '0;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic [$clog2(NREG)-1:0] ra,
    input  logic [$clog2(NREG)-1:0] rb,
    output logic [XLEN-1:0]         rd_a,
    output logic [XLEN-1:0]         rd_b,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic [XLEN-1:0]         wd
);

    localparam int RAW = $clog2(NREG);

    logic [XLEN-1:0] regs_d [NREG];
    logic [XLEN-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != RAW'(0))) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rd_a = (ra == RAW'(0)) ? '0 : regs_q[ra];
    assign rd_b = (rb == RAW'(0)) ? '0 : regs_q[rb];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import risc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_we,
    input  logic            ld_sel_dmem,
    input  logic [XLEN-1:0] ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [XLEN-1:0] peek_addr,
    output logic [XLEN-1:0] peek_data,
    output logic [XLEN-1:0] pc_o
);

    localparam int IAW  = $clog2(IMEM_WORDS);
    localparam int DAW  = $clog2(DMEM_WORDS);
    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [XLEN-1:0] imem_d [IMEM_WORDS];
    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_d [DMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];

    logic [IAW-1:0]  fetch_idx;
    logic [31:0]     instr;
    logic [5:0]      opcode;
    logic [RAW-1:0]  rs_f, rt_f, rd_f;
    logic [15:0]     imm;
    logic [XLEN-1:0] imm_ext;

    ctrl_t           ctrl;
    alu_fn_e         alu_fn;
    logic [XLEN-1:0] rd_a, rd_b, alu_b, alu_y, mem_rdata, wb_data;
    logic            alu_zero;
    logic [RAW-1:0]  wr_addr;
    logic            reg_we, mem_we, br_take;
    logic [DAW-1:0]  data_idx, ld_didx, peek_idx;
    logic [IAW-1:0]  ld_iidx;
    logic [XLEN-1:0] pc_plus4, br_target;

    // fetch and field split
    assign fetch_idx = IAW'(st_q.pc >> 2);
    assign instr     = imem_q[fetch_idx][31:0];
    assign opcode    = instr[31:26];
    assign rs_f      = instr[25:21];
    assign rt_f      = instr[20:16];
    assign rd_f      = instr[15:11];
    assign imm       = instr[15:0];
    assign imm_ext   = {{(XLEN-16){imm[15]}}, imm};

    sc_main_dec u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    sc_alu_ctl u_actl (
        .cls    (ctrl.cls),
        .funct  (instr[5:0]),
        .fn     (alu_fn)
    );

    sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk    (clk),
        .ra     (rs_f),
        .rb     (rt_f),
        .rd_a   (rd_a),
        .rd_b   (rd_b),
        .we     (reg_we),
        .wa     (wr_addr),
        .wd     (wb_data)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : rd_b;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a      (rd_a),
        .b      (alu_b),
        .fn     (alu_fn),
        .y      (alu_y),
        .zero   (alu_zero)
    );

    // data path selection
    always_comb begin
        data_idx  = DAW'(alu_y >> 2);
        mem_rdata = ctrl.mem_rd ? dmem_q[data_idx] : '0;
        wb_data   = ctrl.wb_mem ? mem_rdata : alu_y;
        wr_addr   = ctrl.dst_rd ? rd_f : rt_f;
        reg_we    = ctrl.reg_we & ~rst;
        mem_we    = ctrl.mem_we & ~rst;
        br_take   = ctrl.branch & alu_zero;
        pc_plus4  = st_q.pc + XLEN'(4);
        br_target = pc_plus4 + (imm_ext << 2);
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (br_take) begin
            st_d.pc = br_target;
        end else begin
            st_d.pc = pc_plus4;
        end
    end

    // memory next values
    assign ld_didx  = DAW'(ld_addr);
    assign ld_iidx  = IAW'(ld_addr);
    assign peek_idx = DAW'(peek_addr);

    always_comb begin
        imem_d = imem_q;
        dmem_d = dmem_q;
        if (rst && ld_we) begin
            if (ld_sel_dmem) begin
                dmem_d[ld_didx] = ld_data;
            end else begin
                imem_d[ld_iidx] = ld_data;
            end
        end
        if (mem_we) begin
            dmem_d[data_idx] = rd_b;
        end
    end

    always_ff @(posedge clk) begin
        st_q   <= st_d;
        imem_q <= imem_d;
        dmem_q <= dmem_d;
    end

    assign peek_data = dmem_q[peek_idx];
    assign pc_o      = st_q.pc;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] rd_a,
    input logic [XLEN-1:0] rd_b,
    input logic [4:0]      rs,
    input logic            reg_we,
    input logic            mem_we,
    input logic            mem_rd,
    input logic            br_take
);

    logic known_op;
    assign known_op = (instr[31:26] == 6'h00) || (instr[31:26] == 6'h23) ||
                      (instr[31:26] == 6'h2B) || (instr[31:26] == 6'h04);

    AST_PC_CLEAR: assert property (@(posedge clk) $fell(rst) |-> pc == '0); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        !br_take |=> pc == $past(pc) + XLEN'(4)); // R2

    AST_BR_TARGET: assert property (@(posedge clk) disable iff (rst)
        br_take |=> pc == $past(pc) + XLEN'(4) +
                          {{(XLEN-18){$past(instr[15])}}, $past(instr[15:0]), 2'b00}); // R9

    AST_BR_EQUAL: assert property (@(posedge clk) disable iff (rst)
        br_take |-> rd_a == rd_b); // R10

    AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
        rs == 5'd0 |-> rd_a == '0); // R4

    AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> !reg_we && !mem_we); // R11

    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_we})); // R8

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (st_q.pc),
    .instr   (instr),
    .rd_a    (rd_a),
    .rd_b    (rd_b),
    .rs      (rs_f),
    .reg_we  (reg_we),
    .mem_we  (mem_we),
    .mem_rd  (ctrl.mem_rd),
    .br_take (br_take)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;

    localparam int XLEN = 32;
    localparam int IMW  = 64;
    localparam int DMW  = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ld_we = 1'b0;
    logic            ld_sel_dmem = 1'b0;
    logic [XLEN-1:0] ld_addr = '0;
    logic [XLEN-1:0] ld_data = '0;
    logic [XLEN-1:0] peek_addr = '0;
    logic [XLEN-1:0] peek_data;
    logic [XLEN-1:0] pc_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [31:0] prog [IMW];
    logic [31:0] mreg [8];

    always #2 clk = ~clk;

    sc_core #(.XLEN(XLEN), .IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) u0 (
        .clk         (clk),
        .rst         (rst),
        .ld_we       (ld_we),
        .ld_sel_dmem (ld_sel_dmem),
        .ld_addr     (ld_addr),
        .ld_data     (ld_data),
        .peek_addr   (peek_addr),
        .peek_data   (peek_data),
        .pc_o        (pc_o)
    );

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int s, input int t, input int d);
        return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input logic [15:0] im);
        return {op, 5'(s), 5'(t), im};
    endfunction

    function automatic logic [31:0] ref_op(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
        case (fn)
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_word(input logic sel, input int addr, input logic [31:0] data);
        @(negedge clk);
        ld_we = 1'b1;
        ld_sel_dmem = sel;
        ld_addr = XLEN'(addr);
        ld_data = data;
        @(posedge clk);
        #1;
        ld_we = 1'b0;
    endtask

    task automatic load_prog();
        for (int i = 0; i < IMW; i++) load_word(1'b0, i, prog[i]);
    endtask

    task automatic peek(input int addr, output logic [31:0] val);
        @(negedge clk);
        peek_addr = XLEN'(addr);
        #1;
        val = peek_data;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [5:0] fns [5];
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
        void'($urandom(32'd1234));

        // reset state
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", pc_o, 32'd0);

        // ---------------- directed program ----------------
        for (int i = 0; i < IMW; i++) prog[i] = 32'd0;
        prog[0]  = enc_i(6'h23, 0, 1, 16'd0);          // lw r1,0
        prog[1]  = enc_i(6'h23, 0, 2, 16'd4);          // lw r2,4
        prog[2]  = enc_r(6'h2A, 1, 2, 3);              // slt r3=r1<r2
        prog[3]  = enc_r(6'h2A, 2, 1, 4);              // slt r4=r2<r1
        prog[4]  = enc_r(6'h20, 1, 2, 0);              // add r0 (discarded)
        prog[5]  = enc_i(6'h04, 1, 2, 16'd1);          // beq not taken
        prog[6]  = enc_r(6'h20, 2, 2, 5);              // r5=10
        prog[7]  = enc_i(6'h04, 2, 2, 16'd1);          // beq taken, skips 8
        prog[8]  = enc_r(6'h20, 1, 1, 5);              // skipped
        prog[9]  = enc_i(6'h3F, 0, 5, 16'd80);         // unknown opcode
        prog[10] = enc_i(6'h2B, 0, 5, 16'h1860);       // sw r5 -> word 24, rd field=3
        prog[11] = enc_i(6'h2B, 0, 3, 16'd88);         // sw r3 -> 22
        prog[12] = enc_i(6'h2B, 0, 0, 16'd84);         // sw r0 -> 21
        prog[13] = enc_i(6'h2B, 0, 4, 16'd92);         // sw r4 -> 23
        prog[14] = enc_i(6'h23, 0, 7, 16'd12);         // lw r7=128
        prog[15] = enc_i(6'h2B, 7, 5, 16'hFFF8);       // sw r5 -> word 30
        prog[16] = enc_i(6'h2B, 7, 2, 16'd100);        // sw r2 -> word 57 wraps to 25
        prog[17] = enc_r(6'h22, 2, 1, 6);              // r6 = 5-(-16) = 21
        prog[18] = enc_i(6'h2B, 0, 6, 16'd104);        // sw r6 -> 26
        prog[19] = enc_i(6'h04, 0, 0, 16'hFFFF);       // halt
        load_prog();
        load_word(1'b1, 0, 32'hFFFF_FFF0);
        load_word(1'b1, 1, 32'd5);
        load_word(1'b1, 3, 32'd128);
        load_word(1'b1, 20, 32'hA5A5_A5A5);
        for (int i = 21; i <= 30; i++) load_word(1'b1, i, 32'hDEAD_0000 + 32'(i));

        peek(20, v); chk("R12 loader readback", v, 32'hA5A5_A5A5);

        @(negedge clk); rst = 1'b0;
        @(negedge clk); chk("R2 pc after first edge", pc_o, 32'd4);
        repeat (30) @(negedge clk);
        chk("R9 halt holds pc", pc_o, 32'd76);
        rst = 1'b1;

        peek(20, v); chk("R11 unknown opcode no store", v, 32'hA5A5_A5A5);
        peek(21, v); chk("R4 r0 reads zero", v, 32'd0);
        peek(22, v); chk("R6 signed slt true; R8 no reg write", v, 32'd1);
        peek(23, v); chk("R6 signed slt false", v, 32'd0);
        peek(24, v); chk("R9 R10 branch effects; R11 r5 kept", v, 32'd10);
        peek(30, v); chk("R7 negative offset", v, 32'd10);
        peek(25, v); chk("R7 index wrap", v, 32'd5);
        peek(26, v); chk("R5 sub", v, 32'd21);
        peek(29, v); chk("R8 untouched word", v, 32'hDEAD_001D);

        // ---------------- random program ----------------
        for (int i = 0; i < IMW; i++) prog[i] = 32'd0;
        mreg[0] = 32'd0;
        for (int i = 1; i < 8; i++) begin
            mreg[i] = $urandom;
            load_word(1'b1, i, mreg[i]);
            prog[i-1] = enc_i(6'h23, 0, i, 16'(4 * i));
        end
        for (int k = 0; k < 20; k++) begin
            int s = int'($urandom % 8);
            int t = int'($urandom % 8);
            int d = int'($urandom % 8);
            logic [5:0] f = fns[$urandom % 5];
            prog[7+k] = enc_r(f, s, t, d);
            if (d != 0) mreg[d] = ref_op(f, mreg[s], mreg[t]);
        end
        for (int i = 1; i < 8; i++) prog[26+i] = enc_i(6'h2B, 0, i, 16'(4 * (8 + i)));
        prog[34] = enc_i(6'h04, 0, 0, 16'hFFFF);
        load_prog();

        @(negedge clk); rst = 1'b0;
        repeat (45) @(negedge clk);
        chk("R9 random halt pc", pc_o, 32'd136);
        rst = 1'b1;
        for (int i = 1; i < 8; i++) begin
            peek(8 + i, v);
            chk($sformatf("R3 R5 R6 random r%0d", i), v, mreg[i]);
        end

        finish_run();
    end

endmodule